// File: doc/BRIEF.md
# E1 Receive Frame Alignment Monitor

This block finds and keeps the frame position in a received E1 bit stream made of 256-bit frames. It watches each received bit and looks for the seven-bit alignment word in the first timeslot. Once the word has been confirmed over three frames, the block declares itself aligned. It then marks the start of every frame and says whether that frame carries the alignment word or the non-alignment word. From each non-alignment word it picks up the remote alarm bit.

While aligned, the block checks every alignment word. A run of errored alignment words makes it drop alignment. It then either starts a new search at once or waits, depending on a control pin. A separate detector flags loss of signal when the line delivers a long unbroken run of zeros.

Bits arrive on `rx_bit` qualified by `rx_valid`. The stream has no ready signal. A line receiver cannot be held off, so every bit presented with `rx_valid` high is consumed in that cycle. Cycles with `rx_valid` low are idle and advance no state. Every output is registered and changes only on the clock edge that accepts a bit, except for the step out of the halted state.

Top module: `e1_frame_monitor`

## Requirements
- R1: After reset, `in_sync`, `frame_start`, `is_align_frame`, `remote_alarm` and `los` are all 0.
- R2: Alignment is declared only under three conditions. First, the bits 2..8 of the first timeslot equal 0011011 in one frame (bit 2 arrives first). Second, bit 2 of the first timeslot is 1 in the next frame. Third, the alignment word appears again in the frame after that. `in_sync` rises on the edge that accepts the bit 8 that completes this second alignment word.
- R3: During acquisition, two failures send the block back to a bit-by-bit search, leaving `in_sync` low: a confirming frame whose bit 2 is 0, or a missing second alignment word. A later valid three-frame sequence still acquires.
- R4: Bit 1 of the first timeslot, the international bit, is ignored in every alignment comparison. Either value yields the same behaviour.
- R5: While aligned, `frame_start` pulses for one cycle after the first bit of each frame is accepted. `is_align_frame` is 1 during frames that carry the alignment word and 0 during non-alignment frames. Both outputs are 0 while not aligned.
- R6: `remote_alarm` takes bit 3 of the first timeslot of each non-alignment frame received while aligned. At all other times it holds its value.
- R7: While aligned, three consecutive errored alignment words clear `in_sync` on the edge that accepts bit 8 of the third. A correct alignment word restarts the error count. The content of non-alignment frames never counts as an error.
- R8: When alignment is lost with `auto_resync_en` high, the search restarts immediately. With `auto_resync_en` low, the block stays unaligned regardless of input until the pin goes high, and only then begins searching.
- R9: `los` rises on the edge accepting the 255th consecutive 0 bit, not before. It stays high through further zeros and clears on the edge accepting the next 1 bit.
- R10: A cycle with `rx_valid` low consumes no bit: frame position, error count and zero count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_valid | input | 1 | `rx_bit` carries a new bit this cycle |
| auto_resync_en | input | 1 | 1: search again automatically after loss of alignment |
| in_sync | output | 1 | Frame alignment held |
| frame_start | output | 1 | One-cycle pulse after the first bit of a frame (aligned only) |
| is_align_frame | output | 1 | Current frame carries the alignment word (aligned only) |
| remote_alarm | output | 1 | Last remote alarm bit seen while aligned |
| los | output | 1 | Loss of signal: long run of zeros |

## Verification
The hardest states to reach from the pins are the halted state after a loss with resync disabled, and a loss reached through exactly three errored words with non-alignment frames of wrong content between them. The stimulus builds whole frames from a small set of first-timeslot words: correct and errored alignment words, and good and bad non-alignment words. Payload bits are all ones, so no stray copy of the alignment word can form across boundaries, and every transition lands on a known bit. Resync is switched off before a loss, and valid frames are fed while halted. A frame gap with `rx_valid` low is placed mid-frame to show that idle cycles do not shift the frame position.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  // Receive framer states
  typedef enum logic [2:0] {
    ST_HUNT      = 3'd0,   // bit-by-bit search for the alignment word
    ST_CONF_NFAS = 3'd1,   // expect a non-alignment word next frame
    ST_CONF_FAS  = 3'd2,   // expect the alignment word again
    ST_SYNC      = 3'd3,   // aligned
    ST_HALT      = 3'd4    // lost, waiting for resync permission
  } fa_state_t;

  localparam int unsigned WORD_BITS = 7;
  localparam logic [WORD_BITS-1:0] ALIGN_WORD = 7'b0011011;

endpackage

// File: rtl/e1fa_word_window.sv
module e1fa_word_window #(
  parameter int unsigned           WIDTH   = 7,
  parameter logic [WIDTH-1:0]      PATTERN = 7'b0011011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic word_hit,
  output logic lead_bit,
  output logic second_bit
);
  localparam int unsigned HW = WIDTH - 1;

  logic [HW-1:0]    hist_q;
  logic [WIDTH-1:0] word_now;

  // Window of the last WIDTH bits including the one on the input now
  assign word_now   = {hist_q, bit_in};
  assign word_hit   = (word_now == PATTERN);
  assign lead_bit   = word_now[WIDTH-1];
  assign second_bit = word_now[WIDTH-2];

  // Reset to ones so no stale zero can fake a match
  always_ff @(posedge clk) begin
    if (!rst_n)
      hist_q <= '1;
    else if (bit_valid)
      hist_q <= word_now[HW-1:0];
  end

  p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(hist_q));

endmodule

// File: rtl/e1fa_bit_counter.sv
module e1fa_bit_counter #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned EVAL_POS   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic load,
  output logic at_first,
  output logic at_eval,
  output logic at_last
);
  localparam int unsigned PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] LOAD_POS = PW'(EVAL_POS + 1);
  localparam logic [PW-1:0] EVAL_P   = PW'(EVAL_POS);

  logic [PW-1:0] pos_q;

  assign at_first = (pos_q == '0);
  assign at_eval  = (pos_q == EVAL_P);
  assign at_last  = (pos_q == LAST_POS);

  // load: the bit on the input now is the last bit of an alignment word
  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= '0;
    else if (bit_valid) begin
      if (load)
        pos_q <= LOAD_POS;
      else if (at_last)
        pos_q <= '0;
      else
        pos_q <= pos_q + PW'(1);
    end
  end

  p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(pos_q));

  p_pos_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && at_last && !load) |=> at_first);

endmodule

// File: rtl/e1fa_los_detect.sv
module e1fa_los_detect #(
  parameter int unsigned RUN_LEN = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic los
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_EDGE = CW'(RUN_LEN - 1);

  logic [CW-1:0] zero_run_q;
  logic          los_q;

  assign los = los_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_run_q <= '0;
      los_q      <= 1'b0;
    end else if (bit_valid) begin
      if (bit_in) begin
        zero_run_q <= '0;
        los_q      <= 1'b0;
      end else begin
        if (zero_run_q != RUN_MAX)
          zero_run_q <= zero_run_q + CW'(1);
        if (zero_run_q == RUN_EDGE)
          los_q <= 1'b1;
      end
    end
  end

  p_los_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> ($past(zero_run_q) == RUN_EDGE && $past(bit_valid) && !$past(bit_in)));

  p_los_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_in) |=> !los_q);

endmodule

// File: rtl/e1fa_align_fsm.sv
module e1fa_align_fsm
  import e1fa_pkg::*;
#(
  parameter int unsigned LOF_ERRS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic auto_resync_en,
  input  logic word_hit,
  input  logic nfas_ok,
  input  logic alarm_bit,
  input  logic at_first,
  input  logic at_eval,
  input  logic at_last,
  output logic load,
  output logic in_sync,
  output logic frame_start,
  output logic is_align_frame,
  output logic remote_alarm
);
  localparam int unsigned EW = $clog2(LOF_ERRS + 1);
  localparam logic [EW-1:0] ERR_LAST = EW'(LOF_ERRS - 1);

  fa_state_t     state_q;
  logic [EW-1:0] err_q;
  logic          fas_frame_q;
  logic          ra_q;
  logic          fs_q;
  logic          eval_now;

  assign eval_now       = bit_valid && at_eval;
  assign load           = bit_valid && (state_q == ST_HUNT) && word_hit;
  assign in_sync        = (state_q == ST_SYNC);
  assign is_align_frame = in_sync && fas_frame_q;
  assign frame_start    = fs_q;
  assign remote_alarm   = ra_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_HUNT;
      err_q       <= '0;
      fas_frame_q <= 1'b0;
      ra_q        <= 1'b0;
      fs_q        <= 1'b0;
    end else begin
      fs_q <= bit_valid && at_first && (state_q == ST_SYNC);
      if (bit_valid && at_last && state_q != ST_HUNT)
        fas_frame_q <= ~fas_frame_q;
      unique case (state_q)
        ST_HUNT: begin
          if (load) begin
            state_q     <= ST_CONF_NFAS;
            fas_frame_q <= 1'b1;
          end
        end
        ST_CONF_NFAS: begin
          if (eval_now)
            state_q <= nfas_ok ? ST_CONF_FAS : ST_HUNT;
        end
        ST_CONF_FAS: begin
          if (eval_now) begin
            if (word_hit) begin
              state_q <= ST_SYNC;
              err_q   <= '0;
            end else begin
              state_q <= ST_HUNT;
            end
          end
        end
        ST_SYNC: begin
          if (eval_now) begin
            if (fas_frame_q) begin
              if (word_hit)
                err_q <= '0;
              else if (err_q == ERR_LAST) begin
                err_q   <= '0;
                state_q <= auto_resync_en ? ST_HUNT : ST_HALT;
              end else
                err_q <= err_q + EW'(1);
            end else begin
              ra_q <= alarm_bit;
            end
          end
        end
        ST_HALT: begin
          if (auto_resync_en)
            state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  p_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SYNC) |->
      $past(state_q == ST_CONF_FAS && word_hit && bit_valid && at_eval));

  p_lof_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> ($past(err_q) == ERR_LAST && !$past(word_hit)));

  p_ra_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ra_q) |->
      $past(state_q == ST_SYNC && !fas_frame_q && bit_valid && at_eval));

  p_halt_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !auto_resync_en) |=> (state_q == ST_HALT));

  p_fstart_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> $past(bit_valid && at_first && state_q == ST_SYNC));

endmodule

// File: rtl/e1_frame_monitor.sv
module e1_frame_monitor
  import e1fa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned LOF_ERRS   = 3,
  parameter int unsigned LOS_RUN    = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic auto_resync_en,
  output logic in_sync,
  output logic frame_start,
  output logic is_align_frame,
  output logic remote_alarm,
  output logic los
);
  // Bit 8 of the first timeslot closes the alignment word
  localparam int unsigned EVAL_POS = WORD_BITS;

  logic word_hit;
  logic nfas_ok;
  logic alarm_bit;
  logic at_first;
  logic at_eval;
  logic at_last;
  logic load;

  e1fa_word_window #(
    .WIDTH   (WORD_BITS),
    .PATTERN (ALIGN_WORD)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (rx_valid),
    .bit_in     (rx_bit),
    .word_hit   (word_hit),
    .lead_bit   (nfas_ok),
    .second_bit (alarm_bit)
  );

  e1fa_bit_counter #(
    .FRAME_BITS (FRAME_BITS),
    .EVAL_POS   (EVAL_POS)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (rx_valid),
    .load      (load),
    .at_first  (at_first),
    .at_eval   (at_eval),
    .at_last   (at_last)
  );

  e1fa_align_fsm #(
    .LOF_ERRS (LOF_ERRS)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_valid      (rx_valid),
    .auto_resync_en (auto_resync_en),
    .word_hit       (word_hit),
    .nfas_ok        (nfas_ok),
    .alarm_bit      (alarm_bit),
    .at_first       (at_first),
    .at_eval        (at_eval),
    .at_last        (at_last),
    .load           (load),
    .in_sync        (in_sync),
    .frame_start    (frame_start),
    .is_align_frame (is_align_frame),
    .remote_alarm   (remote_alarm)
  );

  e1fa_los_detect #(
    .RUN_LEN (LOS_RUN)
  ) u_los (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (rx_valid),
    .bit_in    (rx_bit),
    .los       (los)
  );

endmodule

// File: tb/test_e1_frame_monitor.sv
module test_e1_frame_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic rx_valid = 1'b0;
  logic auto_resync_en = 1'b1;
  logic in_sync, frame_start, is_align_frame, remote_alarm, los;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  logic ra_exp = 1'b0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  e1_frame_monitor i_e1_frame_monitor (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .auto_resync_en(auto_resync_en), .in_sync(in_sync),
    .frame_start(frame_start), .is_align_frame(is_align_frame),
    .remote_alarm(remote_alarm), .los(los)
  );

  // expected vector: {in_sync, frame_start, is_align_frame, remote_alarm, los}
  typedef struct {
    int         due;
    logic [4:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  function automatic logic [4:0] observed();
    return {in_sync, frame_start, is_align_frame, remote_alarm, los};
  endfunction

  task automatic compare(input logic [4:0] exp, input string req);
    n_checks++;
    if (observed() !== exp) begin
      n_fails++;
      $display("FAIL %s: got sync/fs/align/ra/los=%b expected %b at cycle %0d",
               req, observed(), exp, cyc);
    end
  endtask

  // monitor: pops the item due in this cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      compare(it.exp, it.req);
    end
  end

  task automatic drive(input logic b, input logic v);
    @(negedge clk);
    rx_bit   = b;
    rx_valid = v;
  endtask

  // called right after drive(): result is visible one edge later
  task automatic push(input logic [4:0] exp, input string req);
    item_t it;
    it.due = cyc + 1;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // ts0[7] is bit 1 (sent first), ts0[0] is bit 8; payload all ones
  task automatic send_frame(input logic [7:0] ts0, input logic is_f,
                            input logic s0, input logic s1,
                            input bit gap, input string req);
    for (int i = 0; i < 256; i++) begin
      if (gap && i == 100) begin
        for (int g = 0; g < 3; g++) drive(1'b0, 1'b0);   // R10 idle cycles
      end
      drive(i < 8 ? ts0[7 - i] : 1'b1, 1'b1);
      if (i == 0)
        push({s0, s0, s0 & is_f, ra_exp, 1'b0}, req);
      if (i == 7) begin
        if (s0 && !is_f) ra_exp = ts0[5];
        push({s1, 1'b0, s1 & is_f, ra_exp, 1'b0}, req);
      end
    end
  endtask

  function automatic logic [7:0] f_word(input logic si);
    return {si, 7'b0011011};
  endfunction
  function automatic logic [7:0] n_word(input logic a);
    return {2'b11, a, 5'b11111};
  endfunction
  function automatic logic [7:0] bad_n(input logic a);
    return {2'b10, a, 5'b11111};
  endfunction
  localparam logic [7:0] E_WORD = 8'b1_0011001;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (5) drive(1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare(5'b00000, "R1 reset state");

    // R9: zero run
    for (int i = 1; i <= 256; i++) begin
      drive(1'b0, 1'b1);
      if (i == 254) push(5'b00000, "R9 no los after 254 zeros");
      if (i == 255) push(5'b00001, "R9 los at 255th zero");
      if (i == 256) push(5'b00001, "R9 los held");
    end
    drive(1'b1, 1'b1);
    push(5'b00000, "R9 los cleared by one");
    for (int i = 0; i < 37; i++) drive(1'b1, 1'b1);

    // R2 acquisition
    send_frame(f_word(1'b0), 1, 0, 0, 0, "R2 first word");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R2 confirm nfas");
    send_frame(f_word(1'b0), 1, 0, 1, 0, "R2 acquired");
    send_frame(n_word(1'b1), 0, 1, 1, 1, "R6 alarm set; R10 gap");
    send_frame(f_word(1'b1), 1, 1, 1, 0, "R4 si=1 ignored; R5");
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R6 alarm clear");

    // R7 error counting with bad nfas in between
    send_frame(E_WORD,      1, 1, 1, 0, "R7 err1");
    send_frame(bad_n(1'b0), 0, 1, 1, 0, "R7 nfas ignored");
    send_frame(E_WORD,      1, 1, 1, 0, "R7 err2");
    send_frame(bad_n(1'b0), 0, 1, 1, 0, "R7 nfas ignored");
    send_frame(f_word(1'b0),1, 1, 1, 0, "R7 count restart");
    send_frame(n_word(1'b0),0, 1, 1, 0, "R7");
    send_frame(E_WORD,      1, 1, 1, 0, "R7 err1 again");
    send_frame(n_word(1'b0),0, 1, 1, 0, "R7");
    send_frame(E_WORD,      1, 1, 1, 0, "R7 err2 again");
    send_frame(n_word(1'b0),0, 1, 1, 0, "R7");
    send_frame(E_WORD,      1, 1, 0, 0, "R7 loss on third");

    // R8 automatic resync
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8 searching");
    send_frame(f_word(1'b1), 1, 0, 0, 0, "R8 searching");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8 searching");
    send_frame(f_word(1'b0), 1, 0, 1, 0, "R8 reacquired");

    // R8 resync disabled
    auto_resync_en = 1'b0;
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R8");
    send_frame(E_WORD,       1, 1, 1, 0, "R8");
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R8");
    send_frame(E_WORD,       1, 1, 1, 0, "R8");
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R8");
    send_frame(E_WORD,       1, 1, 0, 0, "R8 lost while disabled");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8 halted");
    send_frame(f_word(1'b1), 1, 0, 0, 0, "R8 halted");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8 halted");
    send_frame(f_word(1'b1), 1, 0, 0, 0, "R8 halted");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8 halted");
    auto_resync_en = 1'b1;
    send_frame(f_word(1'b1), 1, 0, 0, 0, "R8 search resumed");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R8");
    send_frame(f_word(1'b1), 1, 0, 1, 0, "R8 R4 reacquired");

    // R3 rejected acquisitions
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R3 setup");
    send_frame(E_WORD,       1, 1, 1, 0, "R3 setup");
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R3 setup");
    send_frame(E_WORD,       1, 1, 1, 0, "R3 setup");
    send_frame(n_word(1'b0), 0, 1, 1, 0, "R3 setup");
    send_frame(E_WORD,       1, 1, 0, 0, "R3 setup loss");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R3");
    send_frame(f_word(1'b0), 1, 0, 0, 0, "R3 candidate");
    send_frame(bad_n(1'b1),  0, 0, 0, 0, "R3 bad nfas rejects");
    send_frame(f_word(1'b0), 1, 0, 0, 0, "R3 candidate");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R3");
    send_frame(E_WORD,       1, 0, 0, 0, "R3 missing word rejects");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R3");
    send_frame(f_word(1'b0), 1, 0, 0, 0, "R3 candidate");
    send_frame(n_word(1'b0), 0, 0, 0, 0, "R3");
    send_frame(f_word(1'b0), 1, 0, 1, 0, "R3 acquires after rejects");

    drive(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule